// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through

This block is a first-in first-out buffer whose write port and read port run on two unrelated clocks. Either clock may run at any rate up to the maximum, and no ratio between the two is assumed. Storage is an inferred two-port RAM. The read and write positions cross between the clock domains as Gray-coded pointers through a chain of synchronizing flops.

A strap input picks one of two read behaviours, and the choice takes effect only while master reset is held. In standard mode the read flag reports empty, and a word moves to the output register only when the reader asks for it. In fall-through mode the oldest stored word moves into the output register without a request. The read flag then reports that the output holds valid data, and the write flag reports that there is room to accept a word. Because of these flag meanings, fall-through stages can be chained directly. Each stage's read flag drives the next stage's write enable, and the next stage's write flag drives the previous stage's read enable.

The read side also has an output enable. When it is off, the data pins show zero and a separate indication marks the bus as not driven. The output register keeps its contents while the output is disabled.

Top module: `dual_clock_fifo`

## Requirements
- R1: While `mrst` is high and on the edges that follow its release, both pointers are cleared and `rd_data` is zero. In standard mode (`fwft_sel` = 0 during reset), `rd_flag_n` = 0 (empty) and `wr_flag_n` = 1 (not full). In fall-through mode (`fwft_sel` = 1 during reset), `rd_flag_n` = 1 (no valid output) and `wr_flag_n` = 0 (ready).
- R2: The mode is captured only while `mrst` is high. Changing `fwft_sel` after reset has no effect, so a standard-mode FIFO never presents a word unless asked.
- R3: In fall-through mode, a word written into an empty FIFO appears on `rd_data` at the third rising `rd_clk` edge after the `wr_clk` edge that stored it. At the same edge `rd_flag_n` falls, with `rd_en_n` held high throughout.
- R4: In fall-through mode, the word on the output stays there until `rd_en_n` is low at a rising `rd_clk` edge. That edge presents the next stored word, or raises `rd_flag_n` if nothing is stored.
- R5: In standard mode, `rd_flag_n` rises at the second rising `rd_clk` edge after the first word is stored. `rd_data` changes only at a rising `rd_clk` edge where `rd_en_n` is low and the FIFO is not empty, and that edge loads the oldest word.
- R6: Words leave in the order they were written, in both modes, under any pattern of write and read enables.
- R7: The depth is 2^`ADDR_W` words of storage. In standard mode, `wr_flag_n` falls when that many words are stored. In fall-through mode, `wr_flag_n` rises when that many words wait behind a valid output word. A write attempted while there is no room is dropped.
- R8: A read attempted while empty (standard mode), or while no valid output exists (fall-through mode), leaves `rd_data`, the flags and the pointers unchanged.
- R9: While `rd_oe_n` is high, `rd_data` reads zero and `rd_hiz` is 1. Lowering `rd_oe_n` brings back the held word unchanged.
- R10: Two fall-through instances linked flag-to-enable and data-to-data carry a stream end to end, in order and without loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, held over several edges of both clocks |
| fwft_sel | input | 1 | Mode strap: 1 selects fall-through, 0 selects standard; sampled during reset |
| wr_data | input | DATA_W | Word to store |
| wr_en_n | input | 1 | Write enable, active low |
| wr_flag_n | output | 1 | Standard: full, active low. Fall-through: ready, active low |
| rd_en_n | input | 1 | Read enable, active low |
| rd_oe_n | input | 1 | Output enable, active low |
| rd_data | output | DATA_W | Output register, or zero while disabled |
| rd_hiz | output | 1 | 1 while the output is disabled |
| rd_flag_n | output | 1 | Standard: empty, active low. Fall-through: output valid, active low |

## Verification
Single isolated words measure the flag and data latency in rising read-clock edges. These tests separate the three-edge fall-through path from the two-edge standard-mode empty release, and they show whether a changed strap after reset leaks through. Fill-to-capacity runs followed by one extra write separate a dropped overflow word from a stored one, and reads issued against an empty FIFO show whether the output or the pointers are disturbed. Long streams with mismatched periodic enable patterns on both clocks, and the same kind of stream through two chained instances, test ordering and handshake while the pointers keep crossing domains.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    function automatic logic [31:0] to_gray(input logic [31:0] bin);
        return bin ^ (bin >> 1);
    endfunction

    function automatic rd_mode_e strap_to_mode(input logic strap);
        return strap ? MODE_FWFT : MODE_STD;
    endfunction

endpackage

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_strap,
    input  logic              wr_en_n,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              wr_flag_n
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] FULL_MASK = PTR_W'(3) << (PTR_W - 2);

    rd_mode_e         mode_q;
    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] wbin_nxt;
    logic [PTR_W-1:0] wgray_q;
    logic             full;
    logic             accept;

    assign full     = ((wgray_q ^ rgray_sync) == FULL_MASK);
    assign accept   = !wr_en_n && !full;
    assign wbin_nxt = wbin + PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin    <= '0;
            wgray_q <= '0;
            mode_q  <= strap_to_mode(mode_strap);
        end else if (accept) begin
            wbin    <= wbin_nxt;
            wgray_q <= PTR_W'(to_gray(32'(wbin_nxt)));
        end
    end

    assign mem_we    = accept;
    assign mem_waddr = wbin[ADDR_W-1:0];
    assign wgray     = wgray_q;
    assign wr_flag_n = (mode_q == MODE_FWFT) ? full : !full;

    // R7: the write pointer only moves on an edge where room existed
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(wbin) |-> !$past(full));

    // R6: the pointer handed across domains changes at most one bit per edge
    assert_gray_step_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray_q ^ $past(wgray_q)) <= 1);

    // R2: mode stays as captured during reset
    assert_wmode_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        $stable(mode_q));

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_strap,
    input  logic              rd_en_n,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] q_data,
    output logic              rd_flag_n
);
    localparam int PTR_W = ADDR_W + 1;

    rd_mode_e          mode_q;
    logic [PTR_W-1:0]  rbin;
    logic [PTR_W-1:0]  rbin_nxt;
    logic [PTR_W-1:0]  rgray_q;
    logic [DATA_W-1:0] out_q;
    logic              valid_q;
    logic              mem_empty;
    logic              load;

    assign mem_empty = (rgray_q == wgray_sync);
    assign rbin_nxt  = rbin + PTR_W'(1);

    always_comb begin
        if (mode_q == MODE_FWFT) begin
            load = !mem_empty && (!valid_q || !rd_en_n);
        end else begin
            load = !mem_empty && !rd_en_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin    <= '0;
            rgray_q <= '0;
            out_q   <= '0;
            valid_q <= 1'b0;
            mode_q  <= strap_to_mode(mode_strap);
        end else begin
            if (load) begin
                rbin    <= rbin_nxt;
                rgray_q <= PTR_W'(to_gray(32'(rbin_nxt)));
                out_q   <= mem_rdata;
            end
            if (mode_q == MODE_FWFT) begin
                if (load) begin
                    valid_q <= 1'b1;
                end else if (!rd_en_n) begin
                    valid_q <= 1'b0;
                end
            end
        end
    end

    assign mem_raddr = rbin[ADDR_W-1:0];
    assign rgray     = rgray_q;
    assign q_data    = out_q;
    assign rd_flag_n = (mode_q == MODE_FWFT) ? !valid_q : !mem_empty;

    // R8: the read pointer only moves on an edge where a stored word existed
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(rbin) |-> !$past(mem_empty));

    // R6: the read pointer advances one position at a time
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(rbin) |-> (rbin == $past(rbin) + PTR_W'(1)));

    // R4: a valid fall-through word is held while no read is requested
    assert_fwft_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FWFT && $past(valid_q) && $past(rd_en_n))
            |-> ($stable(out_q) && valid_q));

    // R5: in standard mode the output changes only after a read request
    assert_std_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STD && $past(rd_en_n)) |-> $stable(out_q));

    // R2: mode stays as captured during reset
    assert_rmode_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        $stable(mode_q));

endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst,
    input  logic              fwft_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en_n,
    output logic              wr_flag_n,
    input  logic              rd_en_n,
    input  logic              rd_oe_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_hiz,
    output logic              rd_flag_n
);
    localparam int PTR_W = ADDR_W + 1;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [PTR_W-1:0]  wgray;
    logic [PTR_W-1:0]  rgray;
    logic [PTR_W-1:0]  wgray_in_rd;
    logic [PTR_W-1:0]  rgray_in_wr;
    logic [DATA_W-1:0] q_data;

    dcf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk        (wr_clk),
        .rst        (mrst),
        .mode_strap (fwft_sel),
        .wr_en_n    (wr_en_n),
        .rgray_sync (rgray_in_wr),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .wgray      (wgray),
        .wr_flag_n  (wr_flag_n)
    );

    dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    dcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk (rd_clk),
        .rst (mrst),
        .d   (wgray),
        .q   (wgray_in_rd)
    );

    dcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk (wr_clk),
        .rst (mrst),
        .d   (rgray),
        .q   (rgray_in_wr)
    );

    dcf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk        (rd_clk),
        .rst        (mrst),
        .mode_strap (fwft_sel),
        .rd_en_n    (rd_en_n),
        .wgray_sync (wgray_in_rd),
        .mem_rdata  (mem_rdata),
        .mem_raddr  (mem_raddr),
        .rgray      (rgray),
        .q_data     (q_data),
        .rd_flag_n  (rd_flag_n)
    );

    assign rd_hiz  = rd_oe_n;
    assign rd_data = rd_oe_n ? '0 : q_data;

endmodule

// File: tb/dual_clock_fifo_test.sv
`timescale 1ns/10ps
module dual_clock_fifo_test;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          mrst = 1'b1;
    logic          fwft_sel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_en_n = 1'b1;
    logic          rd_en_n = 1'b1;
    logic          rd_oe_n = 1'b0;
    logic          wr_flag_n;
    logic [DW-1:0] rd_data;
    logic          rd_hiz;
    logic          rd_flag_n;

    int checks = 0;
    int failures = 0;

    // 200 MHz write clock, unrelated 7 ns read clock with offset phase
    always #2.5 wr_clk = ~wr_clk;
    initial begin
        #1.3;
        forever #3.5 rd_clk = ~rd_clk;
    end

    dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .fwft_sel(fwft_sel),
        .wr_data(wr_data), .wr_en_n(wr_en_n), .wr_flag_n(wr_flag_n),
        .rd_en_n(rd_en_n), .rd_oe_n(rd_oe_n), .rd_data(rd_data),
        .rd_hiz(rd_hiz), .rd_flag_n(rd_flag_n)
    );

    // two chained fall-through stages for R10
    logic [DW-1:0] c_wdata = '0;
    logic          c_wen_n = 1'b1;
    logic          c_ren_n = 1'b1;
    logic          c1_wflag_n, c1_rflag_n, c1_hiz, c2_wflag_n, c2_rflag_n, c2_hiz;
    logic [DW-1:0] c1_q, c2_q;

    dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW)) chain1 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .fwft_sel(1'b1),
        .wr_data(c_wdata), .wr_en_n(c_wen_n), .wr_flag_n(c1_wflag_n),
        .rd_en_n(c2_wflag_n), .rd_oe_n(1'b0), .rd_data(c1_q),
        .rd_hiz(c1_hiz), .rd_flag_n(c1_rflag_n)
    );
    dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW)) chain2 (
        .wr_clk(rd_clk), .rd_clk(wr_clk), .mrst(mrst), .fwft_sel(1'b1),
        .wr_data(c1_q), .wr_en_n(c1_rflag_n), .wr_flag_n(c2_wflag_n),
        .rd_en_n(c_ren_n), .rd_oe_n(1'b0), .rd_data(c2_q),
        .rd_hiz(c2_hiz), .rd_flag_n(c2_rflag_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        wr_en_n  = 1'b1;
        rd_en_n  = 1'b1;
        rd_oe_n  = 1'b0;
        mrst     = 1'b1;
        fwft_sel = mode;
        #40;
        @(negedge wr_clk);
        mrst = 1'b0;
        #20;
    endtask

    task automatic wr_word(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_data = d;
        wr_en_n = 1'b0;
        @(negedge wr_clk);
        wr_en_n = 1'b1;
    endtask

    task automatic rd_pulse();
        @(negedge rd_clk);
        rd_en_n = 1'b0;
        @(negedge rd_clk);
        rd_en_n = 1'b1;
    endtask

    // write one word, count rising read edges until the read flag reaches want
    task automatic edges_to_flag(input logic [DW-1:0] d, input logic want, output int n);
        bit found;
        @(negedge wr_clk);
        wr_data = d;
        wr_en_n = 1'b0;
        @(posedge wr_clk);
        #0.1;
        wr_en_n = 1'b1;
        n = 0;
        found = 0;
        for (int k = 0; k < 8 && !found; k++) begin
            @(posedge rd_clk);
            #0.2;
            n++;
            if (rd_flag_n == want) found = 1;
        end
    endtask

    task automatic stream(input bit fw, input int total);
        int q[$];
        int sent;
        int got;
        sent = 0;
        got = 0;
        fork
            begin
                int i;
                i = 0;
                while (sent < total) begin
                    @(negedge wr_clk);
                    if ((fw ? !wr_flag_n : wr_flag_n) && ((i * 5) % 7 < 4)) begin
                        wr_data = DW'(sent * 13 + 7);
                        wr_en_n = 1'b0;
                        q.push_back((sent * 13 + 7) & 8'hFF);
                        sent++;
                    end else begin
                        wr_en_n = 1'b1;
                    end
                    i++;
                end
                @(negedge wr_clk);
                wr_en_n = 1'b1;
            end
            begin
                int j;
                bit pend;
                j = 0;
                pend = 0;
                while (got < total) begin
                    @(negedge rd_clk);
                    if (fw) begin
                        if (!rd_flag_n && ((j * 3) % 5 < 3)) begin
                            chk("R6 fall-through order", rd_data, q.pop_front());
                            got++;
                            rd_en_n = 1'b0;
                        end else begin
                            rd_en_n = 1'b1;
                        end
                    end else begin
                        if (pend) begin
                            chk("R6 standard order", rd_data, q.pop_front());
                            got++;
                        end
                        if (got < total && rd_flag_n && ((j * 3) % 5 < 3)) begin
                            rd_en_n = 1'b0;
                            pend = 1;
                        end else begin
                            rd_en_n = 1'b1;
                            pend = 0;
                        end
                    end
                    j++;
                end
                @(negedge rd_clk);
                rd_en_n = 1'b1;
            end
        join
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        failures++;
        checks++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int n;
        int cq[$];
        int csent;
        int cgot;

        // ---------------- standard mode ----------------
        do_reset(1'b0);
        chk("R1 std empty flag", rd_flag_n, 0);
        chk("R1 std full flag", wr_flag_n, 1);
        chk("R1 std data", rd_data, 0);
        chk("R1 std hiz", rd_hiz, 0);

        // R2: strap changed after reset must not switch to fall-through
        fwft_sel = 1'b1;
        edges_to_flag(8'hA5, 1'b1, n);
        chk("R5 std empty release edges", n, 2);
        repeat (6) @(negedge rd_clk);
        chk("R2 no fall-through after strap change", rd_data, 0);
        chk("R2 flag still empty-style", rd_flag_n, 1);
        rd_pulse();
        chk("R5 std read loads word", rd_data, 8'hA5);
        chk("R5 std empty after read", rd_flag_n, 0);

        // R8: reads against empty
        @(negedge rd_clk);
        rd_en_n = 1'b0;
        repeat (5) @(negedge rd_clk);
        rd_en_n = 1'b1;
        chk("R8 std data kept on empty reads", rd_data, 8'hA5);
        chk("R8 std still empty", rd_flag_n, 0);
        wr_word(8'h3C);
        repeat (5) @(negedge rd_clk);
        chk("R5 std data held without read", rd_data, 8'hA5);
        rd_pulse();
        chk("R8 std pointer intact", rd_data, 8'h3C);

        // R9: output enable
        @(negedge rd_clk);
        rd_oe_n = 1'b1;
        #1;
        chk("R9 data zero when disabled", rd_data, 0);
        chk("R9 hiz indication", rd_hiz, 1);
        @(negedge rd_clk);
        rd_oe_n = 1'b0;
        #1;
        chk("R9 word restored", rd_data, 8'h3C);
        chk("R9 hiz cleared", rd_hiz, 0);

        // R7: fill to capacity, then one extra write
        repeat (6) @(negedge wr_clk);
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(DW'(8'h10 + i));
            chk("R7 std full flag while filling", wr_flag_n, (i == DEPTH - 1) ? 0 : 1);
        end
        wr_word(8'hEE);
        chk("R7 std still full", wr_flag_n, 0);
        repeat (6) @(negedge rd_clk);
        for (int i = 0; i < DEPTH; i++) begin
            rd_pulse();
            chk("R7 std stored word", rd_data, 8'h10 + i);
        end
        chk("R7 std overflow word dropped", rd_flag_n, 0);
        repeat (6) @(negedge wr_clk);
        chk("R7 std room again", wr_flag_n, 1);

        stream(1'b0, 60);

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        chk("R1 fwft output flag", rd_flag_n, 1);
        chk("R1 fwft ready flag", wr_flag_n, 0);
        chk("R1 fwft data", rd_data, 0);

        edges_to_flag(8'h55, 1'b0, n);
        chk("R3 fall-through edges", n, 3);
        chk("R3 fall-through data", rd_data, 8'h55);

        wr_word(8'h66);
        wr_word(8'h77);
        repeat (10) @(negedge rd_clk);
        chk("R4 first word held", rd_data, 8'h55);
        chk("R4 output still valid", rd_flag_n, 0);
        rd_pulse();
        chk("R4 second word", rd_data, 8'h66);
        rd_pulse();
        chk("R4 third word", rd_data, 8'h77);
        rd_pulse();
        chk("R4 flag rises when drained", rd_flag_n, 1);

        @(negedge rd_clk);
        rd_en_n = 1'b0;
        repeat (5) @(negedge rd_clk);
        rd_en_n = 1'b1;
        chk("R8 fwft data kept", rd_data, 8'h77);
        chk("R8 fwft no valid output", rd_flag_n, 1);
        wr_word(8'h88);
        repeat (6) @(negedge rd_clk);
        chk("R8 fwft next word intact", rd_data, 8'h88);
        chk("R8 fwft output valid", rd_flag_n, 0);

        repeat (6) @(negedge wr_clk);
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(DW'(8'h20 + i));
            chk("R7 fwft ready flag while filling", wr_flag_n, (i == DEPTH - 1) ? 1 : 0);
        end
        wr_word(8'hEE);
        chk("R7 fwft still not ready", wr_flag_n, 1);
        chk("R7 fwft head word", rd_data, 8'h88);
        for (int i = 0; i < DEPTH; i++) begin
            rd_pulse();
            chk("R7 fwft stored word", rd_data, 8'h20 + i);
        end
        rd_pulse();
        chk("R7 fwft overflow word dropped", rd_flag_n, 1);

        // R9 in fall-through mode
        @(negedge rd_clk);
        rd_oe_n = 1'b1;
        #1;
        chk("R9 fwft data zero", rd_data, 0);
        @(negedge rd_clk);
        rd_oe_n = 1'b0;
        #1;
        chk("R9 fwft word restored", rd_data, 8'h27);

        stream(1'b1, 60);

        // ---------------- chained stages ----------------
        do_reset(1'b1);
        csent = 0;
        cgot = 0;
        fork
            begin
                int i;
                i = 0;
                while (csent < 24) begin
                    @(negedge wr_clk);
                    if (!c1_wflag_n && (i % 3 != 2)) begin
                        c_wdata = DW'(csent * 11 + 3);
                        c_wen_n = 1'b0;
                        cq.push_back((csent * 11 + 3) & 8'hFF);
                        csent++;
                    end else begin
                        c_wen_n = 1'b1;
                    end
                    i++;
                end
                @(negedge wr_clk);
                c_wen_n = 1'b1;
            end
            begin
                int j;
                j = 0;
                while (cgot < 24) begin
                    @(negedge wr_clk);
                    if (!c2_rflag_n && (j > 60 || j % 4 == 0)) begin
                        chk("R10 chained order", c2_q, cq.pop_front());
                        cgot++;
                        c_ren_n = 1'b0;
                    end else begin
                        c_ren_n = 1'b1;
                    end
                    j++;
                end
                @(negedge wr_clk);
                c_ren_n = 1'b1;
            end
        join
        repeat (10) @(negedge wr_clk);
        chk("R10 chain drained", c2_rflag_n, 1);

        summary();
        $finish;
    end

endmodule